// File: doc/BRIEF.md
# Programmable Video Sync Regenerator

This block rebuilds horizontal and vertical sync pulses for a video stream whose original sync timing has been lost in transport. It runs on the video clock. It watches a data-enable signal that marks active pixels, and a one-cycle strobe that marks the start of vertical blanking. From these it produces active-high `hsync` and `vsync` outputs.

Horizontal sync is not tied to a free-running pixel counter. It is placed relative to the end of each active line. When data-enable drops, a programmable front porch runs, and then a pulse of programmable width. Vertical sync starts right after the blanking strobe and lasts a programmable number of clocks. That number has a hard lower limit of 63 clocks.

Two configuration words are loaded through write strobes. They are assumed to stay static while video is running.

Top module: `sync_regen`

## Requirements
- R1: While `rst_n` is low and after its release, `hsync` and `vsync` are low. The horizontal word resets to 0x0F0F, giving a front porch of 15 and a width of 15. The vertical word resets to 0x003F, giving 63.
- R2: A line ends only on a 1-to-0 transition of `de`, seen as high at one rising clock edge and low at the next.
- R3: Suppose `de` is sampled high at edge k and low at edge k+1, and the front porch is FP. Then `hsync` first goes high just after edge k+1+FP. With FP = 0, `hsync` is high in the very first clock after the last active pixel.
- R4: `hsync` stays high for exactly W clocks, where W is the programmed pulse width. With W = 0, no horizontal pulse is produced.
- R5: A new falling edge of `de` restarts the horizontal sequence, even while a porch or pulse is still running. With FP > 0 this drops `hsync` and runs a fresh porch. With FP = 0 the pulse continues and its W-clock count starts again.
- R6: If `vblank_stb` is sampled high at edge k, `vsync` goes high just after edge k. It stays high for V clocks when the programmed value V is 63 or more.
- R7: A programmed vertical value below 63 still gives a pulse of exactly 63 clocks.
- R8: A `vblank_stb` that arrives while `vsync` is high restarts the vertical count, so the pulse then lasts the full width from that strobe.
- R9: When `hcfg_we` is high at a clock edge, the block loads the front porch from `hcfg_wdata[15:8]` and the pulse width from `hcfg_wdata[7:0]`. When `vcfg_we` is high at a clock edge, it loads the 16-bit vertical width from `vcfg_wdata`.
- R10: A rising edge of `de`, and `de` held high, never assert `hsync`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Video clock |
| rst_n | input | 1 | Active-low synchronous reset |
| de | input | 1 | Data enable, high during active pixels |
| vblank_stb | input | 1 | One-clock strobe at the start of vertical blanking |
| hcfg_we | input | 1 | Load strobe for the horizontal word |
| hcfg_wdata | input | 16 | Front porch in [15:8], pulse width in [7:0] |
| vcfg_we | input | 1 | Load strobe for the vertical word |
| vcfg_wdata | input | 16 | Vertical pulse width in clocks |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |

## Verification
The bound checker watches several things on every cycle:
- A horizontal pulse never outlasts its programmed width, counted from its latest restart.
- No pulse appears when the width is zero.
- `vsync` rises only in the clock after a strobe.
- Every vertical pulse lasts at least the enforced minimum, and never longer than the effective width since the last strobe.

Some behaviour is shown only by the bench's directed scenarios:
- the exact porch delay;
- the fact that pulses reach their full width;
- the reset values of both words;
- restarts in mid-porch and mid-pulse;
- the inertness of a rising `de`.

// File: rtl/sync_regen.sv
module sync_regen #(
  parameter int FP_W   = 8,
  parameter int PW_W   = 8,
  parameter int VW_W   = 16,
  parameter int VMIN   = 63,
  parameter logic [FP_W+PW_W-1:0] HRST = 16'h0F0F,
  parameter logic [VW_W-1:0]      VRST = 16'h003F
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 de,
  input  logic                 vblank_stb,
  input  logic                 hcfg_we,
  input  logic [FP_W+PW_W-1:0] hcfg_wdata,
  input  logic                 vcfg_we,
  input  logic [VW_W-1:0]      vcfg_wdata,
  output logic                 hsync,
  output logic                 vsync
);
  localparam int HCFG_W = FP_W + PW_W;
  localparam int CNT_W  = (FP_W > PW_W) ? FP_W : PW_W;
  localparam logic [VW_W-1:0] VMIN_V = VW_W'(VMIN);

  typedef enum logic [1:0] {H_IDLE, H_PORCH, H_PULSE} hphase_t;

  logic [HCFG_W-1:0] hcfg;
  logic [VW_W-1:0]   vcfg;
  logic              de_q;
  hphase_t           hphase;
  logic [CNT_W-1:0]  hcnt;
  logic [VW_W-1:0]   vcnt;

  logic [FP_W-1:0] hfp;
  logic [PW_W-1:0] hpw;
  logic [VW_W-1:0] veff;
  logic            de_fall;

  assign hfp     = hcfg[HCFG_W-1:PW_W];
  assign hpw     = hcfg[PW_W-1:0];
  assign veff    = (vcfg < VMIN_V) ? VMIN_V : vcfg;
  assign de_fall = de_q & ~de;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hcfg <= HRST;
      vcfg <= VRST;
    end else begin
      if (hcfg_we) hcfg <= hcfg_wdata;
      if (vcfg_we) vcfg <= vcfg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) de_q <= 1'b0;
    else        de_q <= de;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hphase <= H_IDLE;
      hcnt   <= '0;
      hsync  <= 1'b0;
    end else if (de_fall) begin
      if (hfp != '0) begin
        hphase <= H_PORCH;
        hcnt   <= CNT_W'(hfp) - CNT_W'(1);
        hsync  <= 1'b0;
      end else if (hpw != '0) begin
        hphase <= H_PULSE;
        hcnt   <= CNT_W'(hpw) - CNT_W'(1);
        hsync  <= 1'b1;
      end else begin
        hphase <= H_IDLE;
        hsync  <= 1'b0;
      end
    end else begin
      case (hphase)
        H_PORCH: begin
          if (hcnt != '0) begin
            hcnt <= hcnt - CNT_W'(1);
          end else if (hpw != '0) begin
            hphase <= H_PULSE;
            hcnt   <= CNT_W'(hpw) - CNT_W'(1);
            hsync  <= 1'b1;
          end else begin
            hphase <= H_IDLE;
          end
        end
        H_PULSE: begin
          if (hcnt != '0) begin
            hcnt <= hcnt - CNT_W'(1);
          end else begin
            hphase <= H_IDLE;
            hsync  <= 1'b0;
          end
        end
        default: hsync <= 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vsync <= 1'b0;
      vcnt  <= '0;
    end else if (vblank_stb) begin
      vsync <= 1'b1;
      vcnt  <= veff - VW_W'(1);
    end else if (vsync) begin
      if (vcnt == '0) vsync <= 1'b0;
      else            vcnt  <= vcnt - VW_W'(1);
    end
  end
endmodule

module sync_regen_chk #(
  parameter int PW_W = 8,
  parameter int VW_W = 16,
  parameter int VMIN = 63
) (
  input logic            clk,
  input logic            rst_n,
  input logic            de,
  input logic            vblank_stb,
  input logic            hsync,
  input logic            vsync,
  input logic [PW_W-1:0] hpw,
  input logic [VW_W-1:0] veff
);
  logic          de_seen;
  logic [PW_W:0] hlen;
  logic [VW_W:0] vlen;
  logic          fall_seen;

  assign fall_seen = de_seen & ~de;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      de_seen <= 1'b0;
      hlen    <= '0;
      vlen    <= '0;
    end else begin
      de_seen <= de;
      if (fall_seen || !hsync) hlen <= '0;
      else                     hlen <= hlen + 1'b1;
      if (vblank_stb || !vsync) vlen <= '0;
      else                      vlen <= vlen + 1'b1;
    end
  end

  // R4
  hsync_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hsync && !fall_seen) |-> (hlen < {1'b0, hpw}));

  // R4
  hsync_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hsync) |-> (hpw != '0));

  // R6
  vsync_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vsync) |-> $past(vblank_stb));

  // R7
  vsync_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vsync) |-> (vlen >= (VW_W+1)'(VMIN)));

  // R8
  vsync_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vsync && !vblank_stb) |-> (vlen < {1'b0, veff}));
endmodule

bind sync_regen sync_regen_chk #(.PW_W(PW_W), .VW_W(VW_W), .VMIN(VMIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .de(de), .vblank_stb(vblank_stb),
  .hsync(hsync), .vsync(vsync), .hpw(hpw), .veff(veff)
);

// File: tb/sync_regen_bench.sv
module sync_regen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        de = 1'b0;
  logic        vblank_stb = 1'b0;
  logic        hcfg_we = 1'b0;
  logic [15:0] hcfg_wdata = '0;
  logic        vcfg_we = 1'b0;
  logic [15:0] vcfg_wdata = '0;
  logic        hsync, vsync;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sync_regen u_sync_regen (
    .clk(clk), .rst_n(rst_n), .de(de), .vblank_stb(vblank_stb),
    .hcfg_we(hcfg_we), .hcfg_wdata(hcfg_wdata),
    .vcfg_we(vcfg_we), .vcfg_wdata(vcfg_wdata),
    .hsync(hsync), .vsync(vsync)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic set_h(input int fp, input int pw);
    @(negedge clk);
    hcfg_we = 1'b1;
    hcfg_wdata = {fp[7:0], pw[7:0]};
    @(negedge clk);
    hcfg_we = 1'b0;
  endtask

  task automatic set_v(input int v);
    @(negedge clk);
    vcfg_we = 1'b1;
    vcfg_wdata = v[15:0];
    @(negedge clk);
    vcfg_we = 1'b0;
  endtask

  task automatic de_pulse();
    @(negedge clk); de = 1'b1;
    @(negedge clk); de = 1'b0;
  endtask

  task automatic fall_measure(output int first, output int width);
    bit ended = 1'b0;
    first = -1;
    width = 0;
    de_pulse();
    for (int i = 0; i < 700 && !ended; i++) begin
      @(negedge clk);
      if (hsync) begin
        if (first < 0) first = i;
        width++;
      end else if (first >= 0) begin
        ended = 1'b1;
      end
    end
  endtask

  task automatic strobe_measure(output int started, output int width);
    @(negedge clk); vblank_stb = 1'b1;
    @(negedge clk); vblank_stb = 1'b0;
    started = int'(vsync);
    width = 0;
    while (vsync && width < 70000) begin
      width++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check("R1", "hsync in reset", int'(hsync), 0);
    check("R1", "vsync in reset", int'(vsync), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", "hsync after reset", int'(hsync), 0);
    check("R1", "vsync after reset", int'(vsync), 0);
  endtask

  task automatic t_defaults();
    int f, w, s;
    fall_measure(f, w);
    check("R1", "default porch", f, 15);
    check("R1", "default width", w, 15);
    strobe_measure(s, w);
    check("R1", "default vsync start", s, 1);
    check("R1", "default vsync width", w, 63);
  endtask

  task automatic t_porch();
    int f, w;
    set_h(3, 5);
    fall_measure(f, w);
    check("R3", "porch 3 delay", f, 3);
    check("R9", "width 5 loaded", w, 5);
    set_h(0, 4);
    fall_measure(f, w);
    check("R3", "porch 0 delay", f, 0);
    check("R4", "width 4", w, 4);
    set_h(255, 1);
    fall_measure(f, w);
    check("R3", "porch 255 delay", f, 255);
    check("R4", "width 1", w, 1);
  endtask

  task automatic t_zero_width();
    int f, w;
    set_h(2, 0);
    fall_measure(f, w);
    check("R4", "zero width gives no pulse", w, 0);
  endtask

  task automatic t_restart();
    int f, w;
    set_h(4, 6);
    de_pulse();
    repeat (2) @(negedge clk);
    check("R5", "low in porch", int'(hsync), 0);
    fall_measure(f, w);
    check("R5", "restart in porch delay", f, 4);
    check("R5", "restart in porch width", w, 6);
    set_h(2, 8);
    de_pulse();
    repeat (5) @(negedge clk);
    check("R3", "high in pulse", int'(hsync), 1);
    fall_measure(f, w);
    check("R5", "restart in pulse delay", f, 2);
    check("R5", "restart in pulse width", w, 8);
    set_h(0, 6);
    de_pulse();
    repeat (3) @(negedge clk);
    fall_measure(f, w);
    check("R5", "zero porch restart delay", f, 0);
    check("R5", "zero porch restart width", w, 6);
  endtask

  task automatic t_de_rise();
    int highs = 0;
    int f, w;
    set_h(1, 3);
    repeat (5) @(negedge clk);
    de = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (hsync) highs++;
    end
    check("R10", "hsync while de high", highs, 0);
    de = 1'b0;
    repeat (10) @(negedge clk);
    fall_measure(f, w);
    check("R2", "fall after long line delay", f, 1);
    check("R2", "fall after long line width", w, 3);
  endtask

  task automatic t_vsync();
    int s, w;
    set_v(100);
    strobe_measure(s, w);
    check("R6", "vsync start", s, 1);
    check("R6", "vsync width 100", w, 100);
    set_v(10);
    strobe_measure(s, w);
    check("R7", "vsync width 10 clamped", w, 63);
    set_v(0);
    strobe_measure(s, w);
    check("R7", "vsync width 0 clamped", w, 63);
    set_v(64);
    strobe_measure(s, w);
    check("R9", "vsync width 64 loaded", w, 64);
  endtask

  task automatic t_vretrig();
    int s, w;
    set_v(70);
    @(negedge clk); vblank_stb = 1'b1;
    @(negedge clk); vblank_stb = 1'b0;
    repeat (20) @(negedge clk);
    check("R8", "vsync high before retrigger", int'(vsync), 1);
    strobe_measure(s, w);
    check("R8", "retriggered vsync width", w, 70);
  endtask

  initial begin
    t_reset();
    t_defaults();
    t_porch();
    t_zero_width();
    t_restart();
    t_de_rise();
    t_vsync();
    t_vretrig();
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL all watchdog: actual=hung expected=complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule